// File: doc/BRIEF.md
# External DMA Request Decoder

This block stands between an external requesting device and a four-channel DMA engine. The device raises a transfer-request strobe. With the strobe it may present a descriptor word that names a channel and carries a mode field and a size field. It may also raise a bus-request strobe on the same cycle. The decoder checks the descriptor against the rules for the selected channel and chooses the target channel. For each accepted request it emits a one-cycle pulse on that channel's request line. It remembers the most recently requested channel, so that a strobe without a descriptor can repeat it. It counts the outstanding direct-mode requests for channel 2 in a four-slot queue, and it keeps an address-error flag and one transfer-end flag per channel. Software reaches these flags through a small status port, and clears a flag by reading it and then writing it.

The request side carries no back-pressure. A strobe is never stalled. It is accepted, held, dropped or refused in the cycle it is sampled. The refusal of a channel 2 direct request is signalled on `c2_refuse`, and `c2_full` tells the device in advance that the next such request would be refused. Status pins are plain levels and pulses.

Descriptor layout (7 bits): bits [1:0] channel ID, bits [3:2] mode, bits [6:4] size. Status word layout (5 bits): bit 0 is the address-error flag, and bits 4:1 are the transfer-end flags of channels 0 to 3.

Top module: `ext_dma_req_decoder`

## Requirements
- R1: A strobe with a descriptor of ID 0, mode 0 and size other than 5 or 6 produces a one-cycle pulse on `ch_req[0]` in the cycle after the sampling edge.
- R2: A strobe with a descriptor whose ID is 1, 2 or 3 pulses that channel's request line whatever its mode field holds.
- R3: A descriptor with ID 0 and a non-zero mode sets the address-error flag and pulses no channel. While that flag is set, every request is dropped and no pending request is released.
- R4: A flag clears only when a status write with that bit 0 follows a status read that returned 1 for that bit. A write without such a read, a write with the bit 1, or a second write leaves the flag set. When a read and a write fall on the same cycle, the write is acted on first.
- R5: A strobe without a descriptor targets the channel named by the most recent legal descriptor.
- R6: Before any legal descriptor has been seen since reset, a strobe without a descriptor is dropped.
- R7: A descriptor-less strobe that targets channel 0 while the channel 0 transfer-end flag is set produces no pulse and is held pending. After the flag is cleared, the first cycle with no strobe pulses `ch_req[0]` once.
- R8: A strobe raised together with `bus_req` that targets channel 2 is pushed into the queue and pulses `ch_req[2]` if fewer than 4 entries are held. Otherwise it pulses `c2_refuse` and no request line.
- R9: Each `c2_ack` removes one queue entry if any are held, and `c2_full` is high exactly while 4 entries are held.
- R10: `bus_avail` is high in the cycle after one in which `bus_req` was high without the strobe, and low after every cycle with the strobe, including the combined-strobe direct mode.
- R11: A descriptor of ID 0, mode 0 and size 5 or 6 is dropped with no pulse and no error, and it leaves the remembered channel unchanged.
- R12: `te_done[n]` sets the transfer-end flag of channel n. A status read returns the flag word on `reg_rdata` in the next cycle. The setting of a flag wins over a clear in the same cycle.
- R13: At most one request line pulses in any cycle, and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_strobe | input | 1 | Transfer-request strobe |
| bus_req | input | 1 | Bus-request strobe; with `req_strobe` it selects direct mode |
| desc_valid | input | 1 | A descriptor accompanies the strobe |
| desc_word | input | 7 | Descriptor: ID [1:0], mode [3:2], size [6:4] |
| c2_ack | input | 1 | Channel 2 completion acknowledge, pops one queue entry |
| te_done | input | 4 | Per-channel transfer-end set pulses |
| reg_rd | input | 1 | Status read strobe |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 5 | Status write data |
| reg_rdata | output | 5 | Status read data, valid the cycle after `reg_rd` |
| ch_req | output | 4 | One-cycle per-channel request pulses |
| c2_full | output | 1 | Channel 2 queue holds 4 entries |
| c2_refuse | output | 1 | One-cycle pulse: a direct channel 2 request was refused |
| bus_avail | output | 1 | Bus-available indication |

## Verification
Every result of the decoder is registered, so each one is due in the cycle after the edge that samples its stimulus. This holds for request pulses, refusals, `bus_avail` and read data, and also for `c2_full`, which follows the queue count written on that edge. A pending channel 0 request is the one result that is deferred. Its pulse appears one cycle after the first strobe-free edge that follows the clearing write. The bench drives every input on the falling edge, advances a model built from the requirements with those inputs, and compares all outputs to the model's prediction on the next falling edge. Each comparison therefore lands exactly one register stage after its cause.

// File: rtl/xdreq_pkg.sv
package xdreq_pkg;

  // Outcome of decoding one sampled request.
  typedef enum logic [2:0] {
    DEC_IDLE,     // no strobe this cycle
    DEC_ISSUE,    // plain request, pulse the target channel
    DEC_DIRECT,   // combined-strobe request for the queued channel
    DEC_HOLD,     // strobe-only request parked behind a transfer-end flag
    DEC_BADMODE,  // illegal mode for channel 0, raise the address error
    DEC_BADSIZE,  // unsupported size for channel 0, silently dropped
    DEC_NOHIST,   // strobe-only with no remembered channel
    DEC_BLOCKED   // address error pending, request dropped
  } xdreq_dec_e;

endpackage

// File: rtl/xdreq_flags.sv
module xdreq_flags #(
  parameter int NFL = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd,
  input  logic           wr,
  input  logic [NFL-1:0] wdata,
  input  logic [NFL-1:0] set_vec,
  output logic [NFL-1:0] flags,
  output logic [NFL-1:0] rdata
);

  // A bit is armed for clearing only after a read has returned it as 1.
  logic [NFL-1:0] arm;
  logic [NFL-1:0] clr;

  assign clr = wr ? (arm & ~wdata) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      arm   <= '0;
      rdata <= '0;
    end else begin
      flags <= (flags & ~clr) | set_vec;
      if (wr)      arm <= '0;
      else if (rd) arm <= flags;
      if (rd)      rdata <= flags;
    end
  end

  // R4: the error flag only falls after a write carrying 0 in that bit
  p_err_clear_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> ($past(wr) && !$past(wdata[0])));

endmodule

// File: rtl/xdreq_c2q.sv
module xdreq_c2q #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic ack,
  output logic full
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          pop;

  assign pop  = ack && (count != '0);
  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8: the queue never holds more than its depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R8: the decoder never pushes into a full queue
  p_push_has_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

endmodule

// File: rtl/xdreq_route.sv
module xdreq_route
  import xdreq_pkg::*;
#(
  parameter int ID_W      = 2,
  parameter int MD_W      = 2,
  parameter int SZ_W      = 3,
  parameter int DIRECT_CH = 2,
  parameter int HOLD_CH   = 0,
  parameter int BAD_SZ_A  = 5,
  parameter int BAD_SZ_B  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_strobe,
  input  logic                  bus_req,
  input  logic                  desc_valid,
  input  logic [ID_W-1:0]       desc_id,
  input  logic [MD_W-1:0]       desc_mode,
  input  logic [SZ_W-1:0]       desc_size,
  input  logic                  ae_flag,
  input  logic                  te_hold_flag,
  input  logic                  c2_full,
  output logic [(1<<ID_W)-1:0]  ch_req,
  output logic                  ae_set,
  output logic                  c2_push,
  output logic                  c2_refuse
);

  localparam int NCH = 1 << ID_W;
  localparam logic [ID_W-1:0] CH_DIRECT = ID_W'(DIRECT_CH);
  localparam logic [ID_W-1:0] CH_HOLD   = ID_W'(HOLD_CH);

  xdreq_dec_e      dec;
  logic [ID_W-1:0] tgt;
  logic            last_v;
  logic [ID_W-1:0] last_ch;
  logic            pend;
  logic            release_hold;
  logic            bad_size;

  assign bad_size = (desc_size == SZ_W'(BAD_SZ_A)) || (desc_size == SZ_W'(BAD_SZ_B));

  always_comb begin
    dec = DEC_IDLE;
    tgt = last_ch;
    if (req_strobe) begin
      if (ae_flag) begin
        dec = DEC_BLOCKED;
      end else if (desc_valid) begin
        tgt = desc_id;
        if (desc_id == CH_HOLD && desc_mode != '0)  dec = DEC_BADMODE;
        else if (desc_id == CH_HOLD && bad_size)    dec = DEC_BADSIZE;
        else                                        dec = DEC_ISSUE;
      end else if (!last_v) begin
        dec = DEC_NOHIST;
      end else begin
        dec = DEC_ISSUE;
      end
      if (dec == DEC_ISSUE) begin
        if (bus_req && tgt == CH_DIRECT)                  dec = DEC_DIRECT;
        else if (!desc_valid && tgt == CH_HOLD && te_hold_flag) dec = DEC_HOLD;
      end
    end
  end

  assign release_hold = !req_strobe && pend && !te_hold_flag && !ae_flag;
  assign ae_set       = (dec == DEC_BADMODE);
  assign c2_push      = (dec == DEC_DIRECT) && !c2_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_req    <= '0;
      c2_refuse <= 1'b0;
      last_v    <= 1'b0;
      last_ch   <= '0;
      pend      <= 1'b0;
    end else begin
      ch_req    <= '0;
      c2_refuse <= 1'b0;
      case (dec)
        DEC_ISSUE:  ch_req[tgt] <= 1'b1;
        DEC_DIRECT: begin
          if (c2_full) c2_refuse   <= 1'b1;
          else         ch_req[tgt] <= 1'b1;
        end
        DEC_HOLD:   pend <= 1'b1;
        default: ;
      endcase
      if (release_hold) begin
        ch_req[CH_HOLD] <= 1'b1;
        pend            <= 1'b0;
      end
      if (desc_valid && (dec == DEC_ISSUE || dec == DEC_DIRECT)) begin
        last_v  <= 1'b1;
        last_ch <= desc_id;
      end
    end
  end

  // R13: never more than one channel request in a cycle
  p_single_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_req));

  // R8: a refusal only follows a cycle in which the queue reported full
  p_refuse_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c2_refuse |-> $past(c2_full));

  // R8: a refused request never also pulses a channel
  p_refuse_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c2_refuse |-> (ch_req == '0));

  initial begin
    assert (NCH >= 2 && DIRECT_CH < NCH && HOLD_CH < NCH)
      else $error("channel parameters out of range");
  end

endmodule

// File: rtl/ext_dma_req_decoder.sv
module ext_dma_req_decoder #(
  parameter int ID_W      = 2,
  parameter int MD_W      = 2,
  parameter int SZ_W      = 3,
  parameter int Q_DEPTH   = 4,
  parameter int DIRECT_CH = 2,
  parameter int HOLD_CH   = 0,
  parameter int BAD_SZ_A  = 5,
  parameter int BAD_SZ_B  = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_strobe,
  input  logic                         bus_req,
  input  logic                         desc_valid,
  input  logic [ID_W+MD_W+SZ_W-1:0]    desc_word,
  input  logic                         c2_ack,
  input  logic [(1<<ID_W)-1:0]         te_done,
  input  logic                         reg_rd,
  input  logic                         reg_wr,
  input  logic [(1<<ID_W):0]           reg_wdata,
  output logic [(1<<ID_W):0]           reg_rdata,
  output logic [(1<<ID_W)-1:0]         ch_req,
  output logic                         c2_full,
  output logic                         c2_refuse,
  output logic                         bus_avail
);

  localparam int NCH = 1 << ID_W;
  localparam int NFL = NCH + 1;

  logic [ID_W-1:0] d_id;
  logic [MD_W-1:0] d_mode;
  logic [SZ_W-1:0] d_size;
  logic [NFL-1:0]  flags;
  logic            ae_set;
  logic            c2_push;

  assign d_id   = desc_word[ID_W-1:0];
  assign d_mode = desc_word[ID_W+MD_W-1:ID_W];
  assign d_size = desc_word[ID_W+MD_W+SZ_W-1:ID_W+MD_W];

  xdreq_route #(
    .ID_W(ID_W), .MD_W(MD_W), .SZ_W(SZ_W),
    .DIRECT_CH(DIRECT_CH), .HOLD_CH(HOLD_CH),
    .BAD_SZ_A(BAD_SZ_A), .BAD_SZ_B(BAD_SZ_B)
  ) u_route (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_strobe   (req_strobe),
    .bus_req      (bus_req),
    .desc_valid   (desc_valid),
    .desc_id      (d_id),
    .desc_mode    (d_mode),
    .desc_size    (d_size),
    .ae_flag      (flags[0]),
    .te_hold_flag (flags[HOLD_CH+1]),
    .c2_full      (c2_full),
    .ch_req       (ch_req),
    .ae_set       (ae_set),
    .c2_push      (c2_push),
    .c2_refuse    (c2_refuse)
  );

  xdreq_flags #(.NFL(NFL)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (reg_rd),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .set_vec ({te_done, ae_set}),
    .flags   (flags),
    .rdata   (reg_rdata)
  );

  xdreq_c2q #(.DEPTH(Q_DEPTH)) u_c2q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (c2_push),
    .ack   (c2_ack),
    .full  (c2_full)
  );

  // Bus-available answers a bare bus request only; with the transfer
  // strobe the bus-request pin is part of the direct-mode code.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_avail <= 1'b0;
    else        bus_avail <= bus_req && !req_strobe;
  end

  // R3: no channel is requested while the address error stands
  p_quiet_on_error_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] |-> (ch_req == '0));

  // R10: direct-mode requests never raise bus-available
  p_no_bavl_direct_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && bus_req) |=> !bus_avail);

endmodule

// File: tb/sim_ext_dma_req_decoder.sv
`timescale 1ns/1ps
module sim_ext_dma_req_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_strobe = 1'b0, bus_req = 1'b0, desc_valid = 1'b0;
  logic [6:0] desc_word = '0;
  logic       c2_ack = 1'b0;
  logic [3:0] te_done = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic [3:0] ch_req;
  logic       c2_full, c2_refuse, bus_avail;

  always #4 clk = ~clk;

  ext_dma_req_decoder u0 (
    .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .bus_req(bus_req),
    .desc_valid(desc_valid), .desc_word(desc_word), .c2_ack(c2_ack),
    .te_done(te_done), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ch_req(ch_req), .c2_full(c2_full),
    .c2_refuse(c2_refuse), .bus_avail(bus_avail)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  // Reference state, built from the requirements.
  bit       m_ae, m_lv, m_pend;
  bit [3:0] m_te;
  bit [4:0] m_arm, m_rdata;
  bit [1:0] m_last;
  int       m_q;
  bit [3:0] e_ch;
  bit       e_ref, e_bav, e_full;
  string    cur_tag = "R13 reset";

  function automatic bit [6:0] dsc(int id, int md, int sz);
    return {3'(sz), 2'(md), 2'(id)};
  endfunction

  task automatic check(bit ok, string what, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(ch_req == e_ch,       "ch_req",    cur_tag, ch_req,    e_ch);
    check(c2_refuse == e_ref,   "c2_refuse", cur_tag, c2_refuse, e_ref);
    check(c2_full == e_full,    "c2_full",   cur_tag, c2_full,   e_full);
    check(bus_avail == e_bav,   "bus_avail", cur_tag, bus_avail, e_bav);
    check(reg_rdata == m_rdata, "reg_rdata", cur_tag, reg_rdata, m_rdata);
  endtask

  task automatic step(bit s, bit b, bit dv, bit [6:0] d, bit ack, bit [3:0] ted,
                      bit rd, bit wr, bit [4:0] wd, string tag);
    bit [3:0] pulse = '0;
    bit aes = 0, push = 0, refu = 0, ok = 0, pop;
    bit [1:0] id, tgt;
    bit [1:0] md;
    bit [2:0] sz;
    bit [4:0] fl, clr;
    @(negedge clk);
    compare_all();
    req_strobe = s; bus_req = b; desc_valid = dv; desc_word = d; c2_ack = ack;
    te_done = ted; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
    id = d[1:0]; md = d[3:2]; sz = d[6:4]; tgt = m_last;
    if (s) begin
      if (!m_ae) begin
        if (dv) begin
          if (id == 0 && md != 0) aes = 1;
          else if (!(id == 0 && (sz == 5 || sz == 6))) begin ok = 1; tgt = id; end
        end else if (m_lv) ok = 1;
        if (ok) begin
          if (b && tgt == 2) begin
            if (m_q < 4) begin push = 1; pulse[2] = 1; end else refu = 1;
          end else if (!dv && tgt == 0 && m_te[0]) m_pend = 1;
          else pulse[tgt] = 1;
          if (dv) begin m_last = id; m_lv = 1; end
        end
      end
    end else if (m_pend && !m_te[0] && !m_ae) begin
      pulse[0] = 1; m_pend = 0;
    end
    fl  = {m_te, m_ae};
    clr = wr ? (m_arm & ~wd) : 5'd0;
    if (wr)      m_arm = 0;
    else if (rd) m_arm = fl;
    if (rd) m_rdata = fl;
    fl = (fl & ~clr) | {ted, aes};
    m_te = fl[4:1]; m_ae = fl[0];
    pop = ack && m_q > 0;
    m_q = m_q + int'(push) - int'(pop);
    e_ch = pulse; e_ref = refu; e_bav = b && !s; e_full = (m_q == 4);
    cur_tag = tag;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, '0, 0, '0, 0, 0, '0, tag);
  endtask
  task automatic rq(bit b, bit dv, bit [6:0] d, string tag);
    step(1, b, dv, d, 0, '0, 0, 0, '0, tag);
  endtask
  task automatic rd_reg(string tag);
    step(0, 0, 0, '0, 0, '0, 1, 0, '0, tag);
  endtask
  task automatic wr_reg(bit [4:0] wd, string tag);
    step(0, 0, 0, '0, 0, '0, 0, 1, wd, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state is compared by the first step (R13)
    rq(0, 0, '0,               "R6 strobe-only before any descriptor");
    idle("R6 idle");
    rq(0, 1, dsc(0, 0, 0),     "R1 legal channel 0");
    rq(0, 1, dsc(3, 2, 5),     "R2 channel 3 mode ignored");
    rq(0, 0, '0,               "R5 repeat channel 3");
    rq(0, 1, dsc(0, 0, 5),     "R11 bad size 5 dropped");
    rq(0, 1, dsc(0, 0, 6),     "R11 bad size 6 dropped");
    rq(0, 0, '0,               "R11 R5 last channel unchanged");
    rq(0, 1, dsc(1, 3, 1),     "R2 channel 1 mode 3");
    rq(0, 0, '0,               "R5 repeat channel 1");
    // transfer-end hold on channel 0
    step(0, 0, 0, '0, 0, 4'b0001, 0, 0, '0, "R12 set te0");
    rq(0, 1, dsc(0, 0, 2),     "R7 descriptor not held");
    rq(0, 0, '0,               "R7 strobe-only held");
    idle("R7 still held");
    wr_reg(5'b00000,           "R4 R7 write without read");
    idle("R7 still held after bare write");
    rd_reg("R12 read flags");
    idle("R12 rdata");
    wr_reg(5'b11101,           "R4 R7 clear te0");
    idle("R7 release pulse");
    idle("R7 single release");
    // direct mode on channel 2
    for (int k = 0; k < 5; k++) rq(1, 1, dsc(2, 1, 0), "R8 R10 direct ch2");
    idle("R9 full level");
    rq(1, 0, '0,               "R8 R5 strobe-only direct refused");
    step(0, 0, 0, '0, 1, '0, 0, 0, '0, "R9 ack pops");
    rq(1, 1, dsc(2, 0, 0),     "R8 accepted after pop");
    for (int k = 0; k < 5; k++) step(0, 0, 0, '0, 1, '0, 0, 0, '0, "R9 drain");
    // address error
    rq(0, 1, dsc(0, 3, 0),     "R3 illegal mode sets error");
    rq(0, 1, dsc(1, 0, 0),     "R3 blocked while error");
    rq(0, 0, '0,               "R3 strobe-only blocked");
    wr_reg(5'b00000,           "R4 bare write keeps error");
    rd_reg("R4 read error");
    wr_reg(5'b00001,           "R4 write 1 keeps error");
    rq(0, 1, dsc(1, 0, 0),     "R3 still blocked");
    rd_reg("R4 read again");
    step(0, 0, 0, '0, 0, '0, 1, 1, 5'b00000, "R4 read+write same cycle");
    idle("R4 error cleared");
    rq(0, 1, dsc(1, 0, 0),     "R3 requests resume");
    step(0, 1, 0, '0, 0, '0, 0, 0, '0, "R10 bare bus request");
    idle("R10 bus_avail drops");
    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      bit s, b, dv, ack, rd, wr;
      bit [3:0] ted;
      bit [6:0] d;
      s   = ($urandom % 100) < 40;
      dv  = ($urandom % 100) < 70;
      b   = ($urandom % 100) < 30;
      d   = dsc($urandom % 4, (($urandom % 100) < 70) ? 0 : $urandom % 4, $urandom % 8);
      ack = ($urandom % 100) < 20;
      ted = (($urandom % 100) < 6) ? 4'(1 << ($urandom % 4)) : 4'd0;
      rd  = ($urandom % 100) < 15;
      wr  = !rd && (($urandom % 100) < 15);
      step(s, b, dv, d, ack, ted, rd, wr, 5'($urandom & ($urandom)),
           "R1 R2 R3 R4 R5 R7 R8 R9 R10 R12 R13 random");
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule